// File: doc/BRIEF.md
# Floating-point status and control register

This block holds the 32-bit status and control word of a floating-point and SIMD execution unit. Software moves the whole word in and out through a single read/write port. Hardware updates it through three kinds of event inputs. A compare strobe with a 2-bit outcome code rewrites the four condition flags. A saturation pulse sets a sticky saturation flag. Per-class exception pulses set cumulative exception flags, which stay set until software clears them.

The stored mode bits are driven out in two forms. The scalar datapath sees the programmed default-NaN, flush-to-zero and rounding settings. The SIMD datapath always sees default-NaN on, flush-to-zero on and round to nearest. The sticky flags are also exported on a dedicated vector so that logic outside the unit can watch them. A nonzero vector-length field turns every data-processing request into a trap. The block performs no arithmetic; it only stores modes and reports them.

Top module: `fp_stat_ctrl`

## Requirements
- R1: After reset every bit of the register reads 0, `flags_o` is 0 and `trap_o` is low.
- R2: A compare update (`cmp_valid_i` high at a clock edge) loads bits 31:28 (N,Z,C,V) from `cmp_code_i`: 00 less-than gives 1000, 01 equal gives 0110, 10 greater-than gives 0010, 11 unordered gives 0011. Without a strobe or a write, bits 31:28 hold their value.
- R3: Bit 27 (saturation) is set by `sat_i` and stays set until software writes it with 0.
- R4: Bit 7 (input denormal) is set by `denorm_i`; bits 4:0 (inexact, underflow, overflow, divide-by-zero, invalid, from bit 4 down to bit 0) are set by `exc_i[4:0]` bit for bit. Each stays set until software writes it with 0.
- R5: A software write stores bits 26 (alt half-precision), 25 (default NaN), 24 (flush-to-zero), 23:22 (rounding: 00 nearest, 01 toward +inf, 10 toward -inf, 11 toward zero), 21:20 (stride) and 18:16 (vector length). These read back and drive `ahp_o`, `stride_o`, `len_o`, `scal_dn_o`, `scal_fz_o` and `scal_rmode_o`.
- R6: `simd_dn_o` and `simd_fz_o` are always 1 and `simd_rmode_o` is always 00, whatever bits 25:22 hold.
- R7: Bits 19, 15:8 and 6:5 always read 0 and ignore written data.
- R8: `flags_o` is {bit 27, bit 7, bits 4:0} of the register, with bit 27 at position 6.
- R9: `trap_o` is high in the same cycle as `dp_req_i` exactly when bits 18:16 are nonzero.
- R10: When a write and events arrive in the same cycle, the written value is stored and the same-cycle event bits are ORed into the sticky flags. A same-cycle compare replaces the written N, Z, C and V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Current register value |
| cmp_valid_i | input | 1 | Compare result strobe |
| cmp_code_i | input | 2 | Compare outcome code |
| sat_i | input | 1 | Saturation event |
| denorm_i | input | 1 | Input-denormal event |
| exc_i | input | 5 | Exception events (inexact..invalid) |
| dp_req_i | input | 1 | Data-processing request |
| trap_o | output | 1 | Vector-length trap for the request |
| ahp_o | output | 1 | Alternative half-precision select |
| stride_o | output | 2 | Stored stride field |
| len_o | output | 3 | Stored vector-length field |
| scal_dn_o | output | 1 | Scalar default-NaN enable |
| scal_fz_o | output | 1 | Scalar flush-to-zero enable |
| scal_rmode_o | output | 2 | Scalar rounding mode |
| simd_dn_o | output | 1 | SIMD default-NaN enable |
| simd_fz_o | output | 1 | SIMD flush-to-zero enable |
| simd_rmode_o | output | 2 | SIMD rounding mode |
| flags_o | output | 7 | Exported sticky flags |

## Verification
Writes, compare updates and flag events register at a clock edge. Their effect is therefore due on the read port, the mode outputs and `flags_o` one cycle after they are applied. The bench drives each cycle's inputs at the falling edge and compares the outputs at the next falling edge against a bench model that was advanced at the rising edge between them. `trap_o` and the SIMD outputs have no latency, so they are checked one time step after the inputs change, in the same cycle.

// File: rtl/fp_stat_pkg.sv
package fp_stat_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned N_EXC    = 5;
  localparam int unsigned N_STICKY = N_EXC + 2;
  localparam int unsigned RM_W     = 2;
  localparam int unsigned STRIDE_W = 2;
  localparam int unsigned LEN_W    = 3;

  // field positions (software-visible layout)
  localparam int unsigned P_NZCV = 28;
  localparam int unsigned P_SAT  = 27;
  localparam int unsigned P_AHP  = 26;
  localparam int unsigned P_DN   = 25;
  localparam int unsigned P_FZ   = 24;
  localparam int unsigned P_RM   = 22;
  localparam int unsigned P_STR  = 20;
  localparam int unsigned P_LEN  = 16;
  localparam int unsigned P_IDC  = 7;

  typedef enum logic [1:0] {
    CMP_LT = 2'b00,
    CMP_EQ = 2'b01,
    CMP_GT = 2'b10,
    CMP_UN = 2'b11
  } cmp_code_e;

  typedef enum logic [RM_W-1:0] {
    RM_NEAR = 2'b00,
    RM_PINF = 2'b01,
    RM_MINF = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/fp_cond_enc.sv
module fp_cond_enc
  import fp_stat_pkg::*;
(
  input  logic [1:0] code_i,
  output logic [3:0] nzcv_o
);
  always_comb begin
    unique case (cmp_code_e'(code_i))
      CMP_LT:  nzcv_o = 4'b1000;
      CMP_EQ:  nzcv_o = 4'b0110;
      CMP_GT:  nzcv_o = 4'b0010;
      default: nzcv_o = 4'b0011;
    endcase
  end
endmodule

// File: rtl/fp_sticky.sv
module fp_sticky #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= (load_i ? load_val_i[i] : q) | set_i[i];
    end
    assign q_o[i] = q;

    // R3/R4: set flag only drops on a software write of 0
    assert_sticky_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q && !(load_i && !load_val_i[i])) |=> q);
    assert_sticky_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q);
  end
endmodule

// File: rtl/fp_mode_sel.sv
module fp_mode_sel
  import fp_stat_pkg::*;
#(
  parameter bit FORCE_DEFAULTS = 1'b0
) (
  input  logic            dn_i,
  input  logic            fz_i,
  input  logic [RM_W-1:0] rmode_i,
  output logic            dn_o,
  output logic            fz_o,
  output logic [RM_W-1:0] rmode_o
);
  if (FORCE_DEFAULTS) begin : g_forced
    logic unused_mode;
    assign unused_mode = ^{dn_i, fz_i, rmode_i};
    assign dn_o    = 1'b1;
    assign fz_o    = 1'b1;
    assign rmode_o = RM_NEAR;
  end else begin : g_prog
    assign dn_o    = dn_i;
    assign fz_o    = fz_i;
    assign rmode_o = rmode_i;
  end
endmodule

// File: rtl/fp_stat_ctrl.sv
module fp_stat_ctrl
  import fp_stat_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_we_i,
  input  logic [XLEN-1:0]     sw_wdata_i,
  output logic [XLEN-1:0]     sw_rdata_o,
  input  logic                cmp_valid_i,
  input  logic [1:0]          cmp_code_i,
  input  logic                sat_i,
  input  logic                denorm_i,
  input  logic [N_EXC-1:0]    exc_i,
  input  logic                dp_req_i,
  output logic                trap_o,
  output logic                ahp_o,
  output logic [STRIDE_W-1:0] stride_o,
  output logic [LEN_W-1:0]    len_o,
  output logic                scal_dn_o,
  output logic                scal_fz_o,
  output logic [RM_W-1:0]     scal_rmode_o,
  output logic                simd_dn_o,
  output logic                simd_fz_o,
  output logic [RM_W-1:0]     simd_rmode_o,
  output logic [N_STICKY-1:0] flags_o
);
  localparam int unsigned CTRL_W = 3 + RM_W + STRIDE_W + LEN_W;

  logic [3:0]          nzcv_q, nzcv_cmp;
  logic [CTRL_W-1:0]   ctrl_q, ctrl_wr;
  logic [N_STICKY-1:0] sticky_q, sticky_wr, sticky_set;
  logic                unused_wdata;

  assign unused_wdata = ^{sw_wdata_i[19], sw_wdata_i[15:8], sw_wdata_i[6:5]};

  // condition flags: compare wins over a same-cycle write
  fp_cond_enc u_cond (.code_i(cmp_code_i), .nzcv_o(nzcv_cmp));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          nzcv_q <= '0;
    else if (cmp_valid_i) nzcv_q <= nzcv_cmp;
    else if (sw_we_i)     nzcv_q <= sw_wdata_i[P_NZCV +: 4];
  end

  // control fields {ahp, dn, fz, rmode, stride, len}
  assign ctrl_wr = {sw_wdata_i[P_AHP], sw_wdata_i[P_DN], sw_wdata_i[P_FZ],
                    sw_wdata_i[P_RM +: RM_W], sw_wdata_i[P_STR +: STRIDE_W],
                    sw_wdata_i[P_LEN +: LEN_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (sw_we_i) ctrl_q <= ctrl_wr;
  end

  assign ahp_o    = ctrl_q[CTRL_W-1];
  assign stride_o = ctrl_q[LEN_W +: STRIDE_W];
  assign len_o    = ctrl_q[LEN_W-1:0];

  // sticky flags {sat, idc, exc}
  assign sticky_wr  = {sw_wdata_i[P_SAT], sw_wdata_i[P_IDC], sw_wdata_i[N_EXC-1:0]};
  assign sticky_set = {sat_i, denorm_i, exc_i};

  fp_sticky #(.W(N_STICKY)) u_sticky (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sw_we_i),
    .load_val_i(sticky_wr),
    .set_i     (sticky_set),
    .q_o       (sticky_q)
  );
  assign flags_o = sticky_q;

  fp_mode_sel #(.FORCE_DEFAULTS(1'b0)) u_scal (
    .dn_i(ctrl_q[CTRL_W-2]), .fz_i(ctrl_q[CTRL_W-3]),
    .rmode_i(ctrl_q[STRIDE_W+LEN_W +: RM_W]),
    .dn_o(scal_dn_o), .fz_o(scal_fz_o), .rmode_o(scal_rmode_o)
  );

  fp_mode_sel #(.FORCE_DEFAULTS(1'b1)) u_simd (
    .dn_i(ctrl_q[CTRL_W-2]), .fz_i(ctrl_q[CTRL_W-3]),
    .rmode_i(ctrl_q[STRIDE_W+LEN_W +: RM_W]),
    .dn_o(simd_dn_o), .fz_o(simd_fz_o), .rmode_o(simd_rmode_o)
  );

  assign trap_o = dp_req_i && (len_o != '0);

  always_comb begin
    sw_rdata_o = '0;
    sw_rdata_o[P_NZCV +: 4]        = nzcv_q;
    sw_rdata_o[P_SAT]              = sticky_q[N_STICKY-1];
    sw_rdata_o[P_AHP]              = ahp_o;
    sw_rdata_o[P_DN]               = scal_dn_o;
    sw_rdata_o[P_FZ]               = scal_fz_o;
    sw_rdata_o[P_RM +: RM_W]       = scal_rmode_o;
    sw_rdata_o[P_STR +: STRIDE_W]  = stride_o;
    sw_rdata_o[P_LEN +: LEN_W]     = len_o;
    sw_rdata_o[P_IDC]              = sticky_q[N_EXC];
    sw_rdata_o[N_EXC-1:0]          = sticky_q[N_EXC-1:0];
  end

  assert_cmp_eq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && cmp_code_i == 2'b01) |=> sw_rdata_o[31:28] == 4'b0110);
  assert_nzcv_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_valid_i && !sw_we_i) |=> $stable(sw_rdata_o[31:28]));
  assert_ahp_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> ahp_o == $past(sw_wdata_i[P_AHP]));
  assert_trap_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dp_req_i |-> !trap_o);
  assert_wr_sat_merge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && sat_i) |=> flags_o[N_STICKY-1]);
endmodule

// File: tb/fp_stat_ctrl_tb.sv
module fp_stat_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WMASK = 32'hFFF7_009F;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sw_we_i = 0, cmp_valid_i = 0, sat_i = 0, denorm_i = 0, dp_req_i = 0;
  logic [31:0] sw_wdata_i = '0, sw_rdata_o;
  logic [1:0] cmp_code_i = '0, stride_o, scal_rmode_o, simd_rmode_o;
  logic [4:0] exc_i = '0;
  logic [2:0] len_o;
  logic [6:0] flags_o;
  logic trap_o, ahp_o, scal_dn_o, scal_fz_o, simd_dn_o, simd_fz_o;

  int checks = 0, errors = 0;
  logic [31:0] model = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fp_stat_ctrl u_dut (.*);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_next(logic [31:0] cur, logic we, logic [31:0] wd,
      logic cv, logic [1:0] cc, logic sat, logic den, logic [4:0] exc);
    logic [31:0] n;
    n = we ? (wd & WMASK) : cur;
    if (cv) begin
      case (cc)
        2'b00: n[31:28] = 4'b1000;
        2'b01: n[31:28] = 4'b0110;
        2'b10: n[31:28] = 4'b0010;
        default: n[31:28] = 4'b0011;
      endcase
    end
    n[27] |= sat; n[7] |= den; n[4:0] |= exc;
    return n;
  endfunction

  // drive at negedge, model advances across posedge, check at next negedge
  task automatic step(logic we, logic [31:0] wd, logic cv, logic [1:0] cc,
                      logic sat, logic den, logic [4:0] exc, logic req);
    sw_we_i = we; sw_wdata_i = wd; cmp_valid_i = cv; cmp_code_i = cc;
    sat_i = sat; denorm_i = den; exc_i = exc; dp_req_i = req;
    #1;
    check("R9 trap", {31'b0, trap_o}, {31'b0, req && (model[18:16] != 0)});
    check("R6 simd", {27'b0, simd_dn_o, simd_fz_o, simd_rmode_o}, 32'h0000_000C);
    model = model_next(model, we, wd, cv, cc, sat, den, exc);
    @(negedge clk_i);
    check("R2/R3/R4/R5/R7/R10 rdata", sw_rdata_o, model);
    check("R8 flags", {25'b0, flags_o}, {25'b0, model[27], model[7], model[4:0]});
    check("R5 outputs", {20'b0, ahp_o, scal_dn_o, scal_fz_o, scal_rmode_o, stride_o, len_o},
          {20'b0, model[26:16] & 11'h7F7 | 11'h000} >> 0 & 32'h0 |
          {20'b0, model[26], model[25], model[24], model[23:22], model[21:20], model[18:16]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 2);
    check("R1 reset rdata", sw_rdata_o, 32'h0);
    check("R1 reset flags", {25'b0, flags_o}, 32'h0);
    check("R1 reset trap", {31'b0, trap_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7/R5: all ones write, reserved bits drop
    step(1, 32'hFFFF_FFFF, 0, 2'b00, 0, 0, 5'h0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);                       // R9 trap with len=7
    // R5: rounding/stride patterns, len 0 removes trap
    step(1, 32'h0150_0000, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 32'h0089_0000, 0, 0, 0, 0, 0, 1);
    // R2: each compare code
    for (int c = 0; c < 4; c++) step(0, 0, 1, 2'(c), 0, 0, 0, 0);
    // R3: saturation sticky, cleared only by write of 0
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 32'h0800_0000, 0, 0, 0, 0, 0, 0);
    step(1, 32'h0000_0000, 0, 0, 0, 0, 0, 0);
    // R4: each exception bit and denormal
    for (int b = 0; b < 5; b++) step(0, 0, 0, 0, 0, 0, 5'(1 << b), 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    // R10: write of 0 with same-cycle compare and events
    step(1, 32'hF000_0000, 1, 2'b10, 1, 1, 5'h05, 0);
    step(1, 32'h9000_0000, 0, 0, 0, 0, 5'h10, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      step(r[2:0] == 0, $urandom, r[4:3] == 0, r[6:5], r[9:7] == 0, r[12:10] == 0,
           (r[14:13] == 0) ? r[19:15] : 5'h0, r[20]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule